// File: doc/BRIEF.md
# Memory-Reference Instruction Sequencer

This block is the timing and control unit of a small 16-bit accumulator machine. A sequence counter steps through numbered timing states, one per clock. The counter is decoded to a one-hot step vector, and the opcode field is decoded to a one-hot operation vector. Together they decide which register transfer happens in each step. The block owns the program counter, the address register, the instruction register, the data register, the indirect flag and the run flag. It drives read and write strobes to a memory with combinational read data, and it issues operation strobes to an external accumulator datapath.

Each instruction begins with a two-step fetch and a decode step. Memory-reference opcodes can then take an indirect step and run their own execute schedule, which ends by clearing the step counter. Opcode 7 is handed to the external datapath as a register or I/O operation in step 3. If the indirect bit is clear and bit 0 is set, that operation stops the machine. While stopped, the counter and all registers hold their values until reset.

Top module: `mrc_sequencer`

## Requirements
- R1: During reset, the program counter holds RESET_PC (default 0), `run` is high, `seq_t` is 0, and no memory or datapath strobe is active.
- R2: In step 1, `mem_rd` is high with `mem_addr` equal to the program counter (loaded in step 0). The fetched word goes to the instruction register and the program counter increments.
- R3: In step 2, the effective address is taken from instruction bits 11..0 and the indirect flag from bit 15. When the opcode (bits 14..12) is not 7 and bit 15 is 1, step 3 reads memory at that address and its low 12 bits become the effective address.
- R4: Opcodes 0 (AND), 1 (ADD) and 2 (LOAD) read the operand at the effective address in step 4. In step 5 each pulses exactly one of `ac_and`, `ac_add` or `ac_load`, with `dr_q` holding the operand. The instruction takes 6 clocks.
- R5: Opcode 3 (STORE) writes `ac_q` to the effective address in step 4. The instruction takes 5 clocks.
- R6: Opcode 4 (JUMP) loads the program counter with the effective address in step 4. The instruction takes 5 clocks.
- R7: Opcode 5 (CALL) writes the incremented program counter to the effective address in step 4 and continues at the effective address plus 1. The instruction takes 6 clocks.
- R8: Opcode 6 (increment-and-skip) writes the operand plus 1 back in step 6 and skips one word when the written value is 0. The instruction takes 7 clocks.
- R9: Opcode 7 pulses `ext_exec` in step 3, with `ext_io` equal to bit 15 and `ir_low` equal to bits 11..0. The program counter increments if `skip_in` is high in that step. The instruction takes 4 clocks.
- R10: Opcode 7 with bit 15 clear and bit 0 set drops `run`. After that, `seq_t` stays 0, the program counter holds, and no strobe fires. With bit 15 set, bit 0 has no halting effect.
- R11: At most one of `mem_rd` or `mem_wr` is active in a cycle. At most one of `ac_and`, `ac_add`, `ac_load` or `ext_exec` is active in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address (the address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Combinational memory read data |
| ac_q | input | 16 | Accumulator value from the datapath |
| ac_and | output | 1 | Strobe: accumulator AND data register |
| ac_add | output | 1 | Strobe: accumulator plus data register, carry to the link bit |
| ac_load | output | 1 | Strobe: accumulator takes data register |
| dr_q | output | 16 | Data register |
| ext_exec | output | 1 | Strobe: perform register or I/O operation |
| ext_io | output | 1 | Indirect flag; selects the I/O class during `ext_exec` |
| ir_low | output | 12 | Instruction bits 11..0 |
| skip_in | input | 1 | Skip request from the datapath during `ext_exec` |
| pc_q | output | 12 | Program counter |
| run | output | 1 | Run flag; low after a halt |
| seq_t | output | 4 | Current timing step |

## Verification
A wrong step count or a missed clear of the counter shows up within one instruction, as the wrong number of clocks before the halt is seen at `run`. A corrupted address register or indirect flag writes or reads the wrong memory word, and the next fetch exposes it through a wrong final `pc_q` or a wrong word in memory. A bad opcode decode fires the wrong datapath strobe in step 5, and the accumulator then differs once the program halts. The sweep covers every memory-reference opcode in both address modes, with carry-out and zero-crossing operands.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
   // Source selected onto the memory write bus
   typedef enum logic [1:0] {
      WSRC_ACC = 2'd0,
      WSRC_PC  = 2'd1,
      WSRC_DR  = 2'd2
   } wsrc_e;

   localparam int unsigned OPC_W    = 3;   // opcode field width
   localparam int unsigned HALT_BIT = 0;   // stop bit inside the register class
   localparam int unsigned LAST_T   = 6;   // highest step any instruction uses
endpackage

// File: rtl/mrc_onehot_dec.sv
module mrc_onehot_dec #(
   parameter int unsigned IN_W = 3,
   localparam int unsigned OUT_N = 1 << IN_W
) (
   input  logic [IN_W-1:0]  code,
   output logic [OUT_N-1:0] hot
);
   generate
      if (IN_W < 1 || IN_W > 8) begin : g_bad_width
         $error("mrc_onehot_dec: IN_W out of range");
      end
      for (genvar g = 0; g < OUT_N; g++) begin : g_line
         assign hot[g] = (code == IN_W'(g));
      end
   endgenerate
endmodule

// File: rtl/mrc_step_ctr.sv
module mrc_step_ctr #(
   parameter int unsigned SC_W = 4,
   localparam int unsigned STEPS = 1 << SC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             clr,
   output logic [SC_W-1:0]  sc,
   output logic [STEPS-1:0] t
);
   always_ff @(posedge clk) begin
      if (!rst_n)   sc <= '0;
      else if (clr) sc <= '0;
      else if (adv) sc <= sc + SC_W'(1);
   end

   mrc_onehot_dec #(.IN_W(SC_W)) u_tdec (
      .code (sc),
      .hot  (t)
   );
endmodule

// File: rtl/mrc_sequencer.sv
module mrc_sequencer #(
   parameter int unsigned      DATA_W   = 16,
   parameter int unsigned      ADDR_W   = 12,
   parameter int unsigned      SC_W     = 4,
   parameter logic [11:0]      RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] ac_q,
   output logic              ac_and,
   output logic              ac_add,
   output logic              ac_load,
   output logic [DATA_W-1:0] dr_q,
   output logic              ext_exec,
   output logic              ext_io,
   output logic [ADDR_W-1:0] ir_low,
   input  logic              skip_in,
   output logic [ADDR_W-1:0] pc_q,
   output logic              run,
   output logic [SC_W-1:0]   seq_t
);
   import mrc_pkg::*;

   localparam int unsigned STEPS = 1 << SC_W;
   localparam int unsigned OPS   = 1 << OPC_W;
   localparam int unsigned OPC_LO = ADDR_W;
   localparam int unsigned IND_B  = DATA_W - 1;

   generate
      if (DATA_W != ADDR_W + OPC_W + 1) begin : g_bad_fields
         $error("mrc_sequencer: DATA_W must equal ADDR_W + OPC_W + 1");
      end
      if (STEPS <= LAST_T) begin : g_bad_steps
         $error("mrc_sequencer: SC_W too small for the execute schedule");
      end
      if (ADDR_W > 12) begin : g_bad_addr
         $error("mrc_sequencer: RESET_PC holds at most 12 address bits");
      end
   endgenerate

   // Architectural state
   logic [ADDR_W-1:0] pc_r, ar_r;
   logic [DATA_W-1:0] ir_r, dr_r;
   logic              ind_r, run_r;

   // Decoders
   logic [STEPS-1:0] t;
   logic [OPS-1:0]   d;
   logic             sc_clr;

   mrc_step_ctr #(.SC_W(SC_W)) u_steps (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (run_r),
      .clr   (sc_clr),
      .sc    (seq_t),
      .t     (t)
   );

   mrc_onehot_dec #(.IN_W(OPC_W)) u_opdec (
      .code (ir_r[OPC_LO +: OPC_W]),
      .hot  (d)
   );

   // Steps past the last scheduled one are unreachable; fold them back to 0
   logic stray_t;
   assign stray_t = |t[STEPS-1:LAST_T+1];

   // Control decode
   logic  ar_from_pc, ar_from_ir, ar_from_mem, ar_inc;
   logic  pc_from_ar, pc_inc, ir_ld, ind_ld, dr_ld, dr_inc, halt;
   logic  rd_c, wr_c, and_c, add_c, load_c, exec_c;
   logic  mem_class;
   wsrc_e wsrc;

   assign mem_class = ~d[OPS-1];

   always_comb begin
      ar_from_pc  = 1'b0;
      ar_from_ir  = 1'b0;
      ar_from_mem = 1'b0;
      ar_inc      = 1'b0;
      pc_from_ar  = 1'b0;
      pc_inc      = 1'b0;
      ir_ld       = 1'b0;
      ind_ld      = 1'b0;
      dr_ld       = 1'b0;
      dr_inc      = 1'b0;
      halt        = 1'b0;
      rd_c        = 1'b0;
      wr_c        = 1'b0;
      and_c       = 1'b0;
      add_c       = 1'b0;
      load_c      = 1'b0;
      exec_c      = 1'b0;
      sc_clr      = 1'b0;
      wsrc        = WSRC_ACC;
      if (run_r) begin
         if (t[0]) ar_from_pc = 1'b1;
         if (t[1]) begin
            rd_c   = 1'b1;
            ir_ld  = 1'b1;
            pc_inc = 1'b1;
         end
         if (t[2]) begin
            ar_from_ir = 1'b1;
            ind_ld     = 1'b1;
         end
         if (t[3]) begin
            if (!mem_class) begin
               exec_c = 1'b1;
               pc_inc = skip_in;
               halt   = ~ind_r & ir_r[HALT_BIT];
               sc_clr = 1'b1;
            end else if (ind_r) begin
               rd_c        = 1'b1;
               ar_from_mem = 1'b1;
            end
         end
         if (t[4]) begin
            if (d[0] | d[1] | d[2] | d[6]) begin
               rd_c  = 1'b1;
               dr_ld = 1'b1;
            end
            if (d[3]) begin
               wr_c   = 1'b1;
               wsrc   = WSRC_ACC;
               sc_clr = 1'b1;
            end
            if (d[4]) begin
               pc_from_ar = 1'b1;
               sc_clr     = 1'b1;
            end
            if (d[5]) begin
               wr_c   = 1'b1;
               wsrc   = WSRC_PC;
               ar_inc = 1'b1;
            end
         end
         if (t[5]) begin
            and_c  = d[0];
            add_c  = d[1];
            load_c = d[2];
            if (d[0] | d[1] | d[2]) sc_clr = 1'b1;
            if (d[5]) begin
               pc_from_ar = 1'b1;
               sc_clr     = 1'b1;
            end
            if (d[6]) dr_inc = 1'b1;
         end
         if (t[LAST_T]) begin
            if (d[6]) begin
               wr_c   = 1'b1;
               wsrc   = WSRC_DR;
               pc_inc = (dr_r == '0);
            end
            sc_clr = 1'b1;
         end
         if (stray_t) sc_clr = 1'b1;
      end
   end

   // Registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_r  <= RESET_PC[ADDR_W-1:0];
         ar_r  <= '0;
         ir_r  <= '0;
         dr_r  <= '0;
         ind_r <= 1'b0;
         run_r <= 1'b1;
      end else begin
         if (pc_from_ar)  pc_r <= ar_r;
         else if (pc_inc) pc_r <= pc_r + ADDR_W'(1);

         if (ar_from_pc)       ar_r <= pc_r;
         else if (ar_from_ir)  ar_r <= ir_r[ADDR_W-1:0];
         else if (ar_from_mem) ar_r <= mem_rdata[ADDR_W-1:0];
         else if (ar_inc)      ar_r <= ar_r + ADDR_W'(1);

         if (ir_ld) ir_r <= mem_rdata;

         if (dr_ld)       dr_r <= mem_rdata;
         else if (dr_inc) dr_r <= dr_r + DATA_W'(1);

         if (ind_ld) ind_r <= ir_r[IND_B];
         if (halt)   run_r <= 1'b0;
      end
   end

   // Write-data mux
   always_comb begin
      unique case (wsrc)
         WSRC_PC:  mem_wdata = DATA_W'(pc_r);
         WSRC_DR:  mem_wdata = dr_r;
         default:  mem_wdata = ac_q;
      endcase
   end

   assign mem_addr = ar_r;
   assign mem_rd   = rd_c;
   assign mem_wr   = wr_c;
   assign ac_and   = and_c;
   assign ac_add   = add_c;
   assign ac_load  = load_c;
   assign ext_exec = exec_c;
   assign ext_io   = ind_r;
   assign ir_low   = ir_r[ADDR_W-1:0];
   assign dr_q     = dr_r;
   assign pc_q     = pc_r;
   assign run      = run_r;
endmodule

module mrc_sequencer_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned SC_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              ac_and,
   input logic              ac_add,
   input logic              ac_load,
   input logic              ext_exec,
   input logic [ADDR_W-1:0] pc_q,
   input logic              run,
   input logic [SC_W-1:0]   seq_t
);
   localparam logic [ADDR_W-1:0] ONE_A = 1;

   a_r11_one_mem_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr}));

   a_r11_one_dp_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ac_and, ac_add, ac_load, ext_exec}));

   a_r2_fetch_read: assert property (@(posedge clk) disable iff (!rst_n)
      (run && seq_t == SC_W'(1)) |-> (mem_rd && mem_addr == pc_q));

   a_r2_fetch_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (run && seq_t == SC_W'(1)) |=> (pc_q == $past(pc_q) + ONE_A));

   a_r4_alu_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ac_and || ac_add || ac_load) |-> (seq_t == SC_W'(5)));

   a_r4_alu_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (ac_and || ac_add || ac_load) |=> (seq_t == '0));

   a_r9_exec_step: assert property (@(posedge clk) disable iff (!rst_n)
      ext_exec |-> (seq_t == SC_W'(3)));

   a_r9_exec_ends: assert property (@(posedge clk) disable iff (!rst_n)
      ext_exec |=> (seq_t == '0));

   a_r5_write_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (seq_t == SC_W'(4) || seq_t == SC_W'(6)));

   a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!run && $stable(pc_q) && seq_t == '0));

   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !(mem_rd || mem_wr || ac_and || ac_add || ac_load || ext_exec));
endmodule

bind mrc_sequencer mrc_sequencer_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .SC_W   (SC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_addr (mem_addr),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .ac_and   (ac_and),
   .ac_add   (ac_add),
   .ac_load  (ac_load),
   .ext_exec (ext_exec),
   .pc_q     (pc_q),
   .run      (run),
   .seq_t    (seq_t)
);

// File: tb/mrc_sequencer_tb.sv
module mrc_sequencer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata, mem_rdata, ac_q, dr_q;
   logic        ac_and, ac_add, ac_load, ext_exec, ext_io, skip_in, run;
   logic [11:0] ir_low, pc_q;
   logic [3:0]  seq_t;

   int checks = 0;
   int errors = 0;

   logic [15:0] mem [0:255];
   logic [15:0] ac;
   logic [15:0] ac_init = '0;

   always #5 clk = ~clk;

   mrc_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .ac_q(ac_q), .ac_and(ac_and), .ac_add(ac_add), .ac_load(ac_load),
      .dr_q(dr_q), .ext_exec(ext_exec), .ext_io(ext_io), .ir_low(ir_low),
      .skip_in(skip_in), .pc_q(pc_q), .run(run), .seq_t(seq_t)
   );

   // Memory and accumulator models
   assign mem_rdata = mem[mem_addr[7:0]];
   assign ac_q      = ac;
   assign skip_in   = ext_exec & ~ext_io & ir_low[2] & (ac == 16'h0);

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
      if (!rst_n)       ac <= ac_init;
      else if (ac_and)  ac <= ac & dr_q;
      else if (ac_add)  ac <= ac + dr_q;
      else if (ac_load) ac <= dr_q;
      else if (ext_exec && !ext_io) begin
         if (ir_low[11])     ac <= 16'h0;
         else if (ir_low[5]) ac <= ac + 16'h1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;
   endtask

   // Reset, then run until halt; returns clocks taken
   task automatic run_prog(input logic [15:0] acv, input bit chk_rst, output int cyc);
      ac_init = acv;
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      if (chk_rst) begin
         chk("R1 pc", 32'(pc_q), 32'h0);
         chk("R1 run", 32'(run), 32'h1);
         chk("R1 step", 32'(seq_t), 32'h0);
         chk("R1 strobes", 32'({mem_rd, mem_wr, ac_and, ac_add, ac_load, ext_exec}), 32'h0);
      end
      rst_n = 1'b1;
      cyc = 0;
      for (int k = 0; k < 200; k++) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (!run) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int cyc;
      logic [15:0] vals [3];
      vals[0] = 16'h0F0F;
      vals[1] = 16'hFFFF;
      vals[2] = 16'h8001;

      // Sweep: every memory-reference opcode, direct and indirect, three operands
      for (int op = 0; op < 7; op++) begin
         for (int ind = 0; ind < 2; ind++) begin
            for (int v = 0; v < 3; v++) begin
               logic [15:0] dat, acv, ea, exp_ac, exp_mem;
               logic [11:0] exp_pc;
               int exp_cyc;
               string tag;
               dat = vals[v];
               acv = 16'h3C5A;
               ea  = (ind != 0) ? 16'h050 : 16'h040;
               clear_mem();
               mem[0] = {ind[0], op[2:0], 12'h040};
               mem[1] = 16'h7001;
               mem[2] = 16'h7001;
               if (ind != 0) mem[16'h40] = 16'h0050;
               mem[ea[7:0]] = dat;
               exp_ac = acv; exp_mem = dat; exp_pc = 12'd2; exp_cyc = 6 + 4;
               case (op)
                  0: begin exp_ac = acv & dat; tag = "R4 and"; end
                  1: begin exp_ac = acv + dat; tag = "R4 add"; end
                  2: begin exp_ac = dat;       tag = "R4 load"; end
                  3: begin exp_mem = acv; exp_cyc = 5 + 4; tag = "R5 store"; end
                  4: begin
                     mem[ea[7:0]] = 16'h7001; exp_mem = 16'h7001;
                     exp_pc = ea[11:0] + 12'd1; exp_cyc = 5 + 4; tag = "R6 jump";
                  end
                  5: begin
                     mem[ea[7:0] + 8'd1] = 16'h7001; exp_mem = 16'h0001;
                     exp_pc = ea[11:0] + 12'd2; tag = "R7 call";
                  end
                  default: begin
                     exp_mem = dat + 16'h1; exp_cyc = 7 + 4; tag = "R8 isz";
                     if (exp_mem == 16'h0) exp_pc = 12'd3;
                  end
               endcase
               run_prog(acv, (op == 0 && ind == 0 && v == 0), cyc);
               if (ind != 0) tag = {tag, " R3 indirect"};
               chk({tag, " ac"}, 32'(ac), 32'(exp_ac));
               chk({tag, " mem"}, 32'(mem[ea[7:0]]), 32'(exp_mem));
               chk({tag, " pc R2"}, 32'(pc_q), 32'(exp_pc));
               chk({tag, " clocks"}, 32'(cyc), 32'(exp_cyc));
            end
         end
      end

      // R9: register class, clear then increment, then skip on zero
      clear_mem();
      mem[0] = 16'h7800;  // clear
      mem[1] = 16'h7004;  // skip if zero -> skips mem[2]
      mem[2] = 16'h7001;
      mem[3] = 16'h7020;  // increment
      mem[4] = 16'h7001;
      run_prog(16'h1234, 1'b0, cyc);
      chk("R9 ac after clear+inc", 32'(ac), 32'h1);
      chk("R9 skip taken pc", 32'(pc_q), 32'h5);
      chk("R9 clocks", 32'(cyc), 32'd16);

      // R9: skip not taken when accumulator nonzero
      clear_mem();
      mem[0] = 16'h7004;
      mem[1] = 16'h7001;
      run_prog(16'h0007, 1'b0, cyc);
      chk("R9 no skip pc", 32'(pc_q), 32'h2);
      chk("R9 no skip ac", 32'(ac), 32'h7);

      // R10: I/O class with bit 0 set must not halt
      clear_mem();
      mem[0] = 16'hF001;
      mem[1] = 16'h7001;
      run_prog(16'h0000, 1'b0, cyc);
      chk("R10 io no halt pc", 32'(pc_q), 32'h2);
      chk("R10 io no halt clocks", 32'(cyc), 32'd8);

      // R10: machine stays frozen after halt
      begin
         logic [11:0] pc_hold;
         int strobes = 0;
         pc_hold = pc_q;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || ext_exec || ac_and || ac_add || ac_load) strobes++;
         end
         chk("R10 pc held", 32'(pc_q), 32'(pc_hold));
         chk("R10 step held", 32'(seq_t), 32'h0);
         chk("R10 run low", 32'(run), 32'h0);
         chk("R10 no strobes", 32'(strobes), 32'h0);
      end

      // R11 / R4: three-instruction program chaining load, add, store
      clear_mem();
      mem[0]  = 16'h2010;  // load [0x10]
      mem[1]  = 16'h1011;  // add  [0x11]
      mem[2]  = 16'h3012;  // store [0x12]
      mem[3]  = 16'h7001;
      mem[16] = 16'h8000;
      mem[17] = 16'h8001;
      run_prog(16'hAAAA, 1'b0, cyc);
      chk("R11 chain sum", 32'(mem[18]), 32'h0001);
      chk("R11 chain clocks", 32'(cyc), 32'd21);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule